// File: doc/BRIEF.md
# Sector DMA Controller

This block lets a processor hand a single-sector copy to hardware. Software programs three port registers through a narrow write port: the logical block number of the sector, the byte address in main memory where the sector must land, and a command word. Writing the read command starts the transfer. From then on the controller works without the processor. It fetches the sector one word at a time from a request/valid storage interface. It pushes each word into memory through a master write port that waits for a grant.

When the last word of the sector has been accepted by memory, the controller returns to idle and raises an interrupt line. The line stays high until software writes the acknowledge register. If software issues a command while a transfer is still running, the command is dropped and a sticky error flag is raised. The acknowledge write also clears that flag.

The sequencer has three states. `ST_IDLE` waits for a start. `ST_FETCH` holds a storage request until data is returned. `ST_STORE` holds a memory write until it is granted. The transitions are:

- `ST_IDLE` to `ST_FETCH` on an accepted read command.
- `ST_FETCH` to `ST_STORE` on `st_valid`.
- `ST_STORE` to `ST_FETCH` on a grant for any word but the last.
- `ST_STORE` to `ST_IDLE` on the grant of the last word. This transition is the completion event.

Top module: `sector_dma_ctrl`

## Requirements
- R1: While reset is held and in the cycle after its release, `busy`, `irq`, `err`, `st_req` and `mem_req` are all low.
- R2: A write to register select 0 (command) with data value 1 while idle starts a transfer. After that clock edge, `busy` and `st_req` are high and `st_word` is 0. A command write with any other value while idle changes nothing.
- R3: `st_req` stays high with stable `st_lbn` and `st_word` until a cycle in which `st_valid` is high. The `st_rdata` of that cycle is the word that is then written to memory.
- R4: Word i of the sector (i = 0..7, 32-bit words) is written to address DST + 4*i, in ascending order of i. DST is the value written to register select 2. `mem_req` stays high with stable `mem_addr` and `mem_wdata` until `mem_gnt` is seen high.
- R5: The memory address and the word index advance only on a cycle where `mem_req` and `mem_gnt` are both high.
- R6: A transfer writes exactly 8 words. After the edge on which the eighth write is granted, `busy` is low and `irq` is high.
- R7: `irq` remains high until a write to register select 3 (acknowledge). That write clears it on the next edge, unless a transfer completes on that same edge.
- R8: A write to register select 0 while `busy` is high does not alter the running transfer and sets `err`. `err` stays high until an acknowledge write.
- R9: The block number (register select 1) and destination (register select 2) are captured when a transfer starts. Writes to them during a transfer do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_sel | input | 2 | Register select: 0 command, 1 block number, 2 destination, 3 acknowledge |
| reg_wdata | input | DATA_W | Register write data |
| st_req | output | 1 | Storage word request |
| st_lbn | output | DATA_W | Block number of the requested sector |
| st_word | output | IDX_W | Index of the requested word within the sector |
| st_valid | input | 1 | Storage returns `st_rdata` this cycle |
| st_rdata | input | DATA_W | Storage read data |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Memory accepts the write this cycle |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt, level |
| err | output | 1 | Sticky command-while-busy error |

## Verification
A wrong sequencer state shows up on `st_req`, `mem_req` or `busy` in the very cycle after the faulty edge, because all three are decoded directly from the state. A corrupted word index or address register shows up as a wrong `st_word` or `mem_addr` as soon as the next request is raised. It also leaves a hole or a misplaced word in the memory image that the bench gathers from granted writes. A stale block-number or data latch is seen on `st_lbn` or `mem_wdata`. Faults in the flags, such as a lost set, an early clear or a missed acknowledge, appear on `irq` or `err` one edge after the causing event, since the bench compares every output against its model every cycle.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } sdma_state_e;

    typedef enum logic [1:0] {
        SEL_CMD = 2'd0,
        SEL_LBN = 2'd1,
        SEL_DST = 2'd2,
        SEL_ACK = 2'd3
    } sdma_sel_e;

    localparam int unsigned OP_READ = 1;

endpackage

// File: rtl/sdma_port_regs.sv
module sdma_port_regs
    import sdma_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    output logic              start,
    output logic              cmd_rejected,
    output logic              ack,
    output logic [DATA_W-1:0] lbn_q,
    output logic [ADDR_W-1:0] dst_q
);

    logic cmd_wr;
    logic is_read_op;

    always_comb begin
        cmd_wr       = reg_wr && (reg_sel == SEL_CMD);
        is_read_op   = (reg_wdata == DATA_W'(OP_READ));
        start        = cmd_wr && is_read_op && !busy;
        cmd_rejected = cmd_wr && busy;
        ack          = reg_wr && (reg_sel == SEL_ACK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lbn_q <= '0;
            dst_q <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_LBN) lbn_q <= reg_wdata;
            if (reg_sel == SEL_DST) dst_q <= reg_wdata[ADDR_W-1:0];
        end
    end

    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CMD && busy) |-> !start);

endmodule

// File: rtl/sdma_sequencer.sv
module sdma_sequencer
    import sdma_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WORDS  = 8,
    localparam int unsigned IDX_W = $clog2(WORDS),
    localparam int unsigned STEP  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] lbn_in,
    input  logic [ADDR_W-1:0] dst_in,
    output logic              st_req,
    output logic [DATA_W-1:0] st_lbn,
    output logic [IDX_W-1:0]  st_word,
    input  logic              st_valid,
    input  logic [DATA_W-1:0] st_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    output logic              busy,
    output logic              done
);

    sdma_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] lbn_q;
    logic [DATA_W-1:0] data_q;
    logic              last_word;
    logic              accepted;

    assign last_word = (idx_q == IDX_W'(WORDS - 1));
    assign accepted  = (state_q == ST_STORE) && mem_gnt;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_FETCH;
            ST_FETCH: if (st_valid) state_d = ST_STORE;
            ST_STORE: if (mem_gnt)  state_d = last_word ? ST_IDLE : ST_FETCH;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            addr_q <= '0;
            lbn_q  <= '0;
            data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                idx_q  <= '0;
                addr_q <= dst_in;
                lbn_q  <= lbn_in;
            end
            if (state_q == ST_FETCH && st_valid) data_q <= st_rdata;
            if (accepted) begin
                idx_q  <= idx_q + 1'b1;
                addr_q <= addr_q + ADDR_W'(STEP);
            end
        end
    end

    // outputs
    always_comb begin
        st_req    = 1'b0;
        mem_req   = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy    = 1'b0;
            ST_FETCH: st_req  = 1'b1;
            ST_STORE: mem_req = 1'b1;
            default:  busy    = 1'b0;
        endcase
        st_lbn    = lbn_q;
        st_word   = idx_q;
        mem_addr  = addr_q;
        mem_wdata = data_q;
        done      = accepted && last_word;
    end

    assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_valid) |=> (st_req && $stable(st_word) && $stable(st_lbn)));

    assert_store_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !done) |=>
            (st_req && mem_addr == $past(mem_addr) + ADDR_W'(STEP)));

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (st_req && st_word == '0));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/sdma_flags.sv
module sdma_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic ack,
    input  logic cmd_rejected,
    output logic irq,
    output logic err
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            err <= 1'b0;
        end else begin
            if (done)     irq <= 1'b1;
            else if (ack) irq <= 1'b0;
            if (cmd_rejected) err <= 1'b1;
            else if (ack)     err <= 1'b0;
        end
    end

    assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq);

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rejected |=> err);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !ack) |=> err);

endmodule

// File: rtl/sector_dma_ctrl.sv
module sector_dma_ctrl
    import sdma_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WORDS  = 8,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              st_req,
    output logic [DATA_W-1:0] st_lbn,
    output logic [IDX_W-1:0]  st_word,
    input  logic              st_valid,
    input  logic [DATA_W-1:0] st_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    output logic              busy,
    output logic              irq,
    output logic              err
);

    logic              start;
    logic              cmd_rejected;
    logic              ack;
    logic              done;
    logic [DATA_W-1:0] lbn_cfg;
    logic [ADDR_W-1:0] dst_cfg;

    sdma_port_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .busy         (busy),
        .start        (start),
        .cmd_rejected (cmd_rejected),
        .ack          (ack),
        .lbn_q        (lbn_cfg),
        .dst_q        (dst_cfg)
    );

    sdma_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lbn_in    (lbn_cfg),
        .dst_in    (dst_cfg),
        .st_req    (st_req),
        .st_lbn    (st_lbn),
        .st_word   (st_word),
        .st_valid  (st_valid),
        .st_rdata  (st_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .busy      (busy),
        .done      (done)
    );

    sdma_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .done         (done),
        .ack          (ack),
        .cmd_rejected (cmd_rejected),
        .irq          (irq),
        .err          (err)
    );

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!busy && !irq && !err && !st_req && !mem_req));

endmodule

// File: tb/sector_dma_ctrl_test.sv
`timescale 1ns/1ps
module sector_dma_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        st_req;
    logic [31:0] st_lbn;
    logic [2:0]  st_word;
    logic        st_valid = 1'b0;
    logic [31:0] st_rdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        busy, irq, err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int st_period  = 1;
    int gnt_period = 1;

    logic [31:0] memimg [logic [31:0]];

    // reference model state
    int          m_st = 0;     // 0 idle, 1 fetch, 2 store
    int          m_idx = 0;
    logic [31:0] m_lbn = '0, m_dst_cfg = '0, m_lbn_cfg = '0, m_addr = '0, m_data = '0;
    bit          m_irq = 0, m_err = 0;

    always #4 clk = ~clk;

    sector_dma_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .st_req(st_req), .st_lbn(st_lbn), .st_word(st_word), .st_valid(st_valid),
        .st_rdata(st_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .busy(busy), .irq(irq), .err(err)
    );

    function automatic logic [31:0] sector_word(logic [31:0] lbn, int idx);
        return {lbn[23:0], 8'(idx)} ^ 32'h5A00_0000;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_irq = 0; m_err = 0;
            m_lbn_cfg = '0; m_dst_cfg = '0;
        end else begin
            bit cmdw, ackw, fin;
            cmdw = reg_wr && reg_sel == 2'd0;
            ackw = reg_wr && reg_sel == 2'd3;
            fin  = (m_st == 2) && mem_gnt && (m_idx == 7);
            if (fin) m_irq = 1; else if (ackw) m_irq = 0;
            if (cmdw && m_st != 0) m_err = 1; else if (ackw) m_err = 0;
            if (mem_req && mem_gnt) memimg[mem_addr] = mem_wdata;
            case (m_st)
                0: if (cmdw && reg_wdata == 32'd1) begin
                       m_st = 1; m_idx = 0; m_lbn = m_lbn_cfg; m_addr = m_dst_cfg;
                   end
                1: if (st_valid) begin m_st = 2; m_data = st_rdata; end
                2: if (mem_gnt) begin
                       m_addr = m_addr + 32'd4;
                       if (m_idx == 7) m_st = 0; else begin m_idx++; m_st = 1; end
                   end
                default: m_st = 0;
            endcase
            if (reg_wr && reg_sel == 2'd1) m_lbn_cfg = reg_wdata;
            if (reg_wr && reg_sel == 2'd2) m_dst_cfg = reg_wdata;
        end
    end

    // per-cycle comparison and storage/memory responders, at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2", 32'(busy), 32'(m_st != 0), "busy");
            check("R3", 32'(st_req), 32'(m_st == 1), "st_req");
            check("R4", 32'(mem_req), 32'(m_st == 2), "mem_req");
            check("R7", 32'(irq), 32'(m_irq), "irq");
            check("R8", 32'(err), 32'(m_err), "err");
            if (m_st == 1) begin
                check("R9", st_lbn, m_lbn, "st_lbn");
                check("R5", 32'(st_word), 32'(m_idx), "st_word");
            end
            if (m_st == 2) begin
                check("R4", mem_addr, m_addr, "mem_addr");
                check("R3", mem_wdata, m_data, "mem_wdata");
            end
        end
        st_valid <= st_req && (cyc % st_period == 0);
        st_rdata <= st_req ? sector_word(st_lbn, int'(st_word)) : 32'hDEAD_BEEF;
        mem_gnt  <= (cyc % gnt_period == 0);
    end

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_image(logic [31:0] lbn, logic [31:0] dst);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] a;
            a = dst + 32'(4 * i);
            if (memimg.exists(a)) check("R4", memimg[a], sector_word(lbn, i), "memory word");
            else check("R6", 32'hFFFF_FFFF, 32'(i), "missing memory word");
        end
        check("R6", 32'(memimg.num()), 32'd8, "number of words written");
    endtask

    initial begin : watchdog
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {27'd0, busy, irq, err, st_req, mem_req}, 32'd0, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {27'd0, busy, irq, err, st_req, mem_req}, 32'd0, "outputs after reset");

        // transfer 1: wrong opcode ignored, then a clean read
        wr(2'd1, 32'd5);
        wr(2'd2, 32'h0000_1000);
        wr(2'd0, 32'd2);
        check("R2", 32'(busy), 32'd0, "busy after non-read opcode");
        memimg.delete();
        wr(2'd0, 32'd1);
        wait_idle();
        check_image(32'd5, 32'h0000_1000);
        check("R6", 32'(irq), 32'd1, "irq after completion");
        repeat (5) @(negedge clk);
        check("R7", 32'(irq), 32'd1, "irq held without ack");
        wr(2'd3, 32'd0);
        check("R7", 32'(irq), 32'd0, "irq cleared by ack");

        // transfer 2: stalls on both sides, command and register writes while busy
        st_period = 3; gnt_period = 4;
        wr(2'd1, 32'h00AB_CDEF);
        wr(2'd2, 32'h0002_0040);
        memimg.delete();
        wr(2'd0, 32'd1);
        repeat (4) @(negedge clk);
        wr(2'd0, 32'd1);
        wr(2'd1, 32'd99);
        wr(2'd2, 32'h0009_0000);
        check("R8", 32'(err), 32'd1, "err after command while busy");
        wait_idle();
        check_image(32'h00AB_CDEF, 32'h0002_0040);
        check("R8", 32'(err), 32'd1, "err sticky after completion");
        wr(2'd3, 32'd0);
        check("R8", 32'(err), 32'd0, "err cleared by ack");

        // transfer 3: address wrap, back-to-back grants, then one more without ack
        st_period = 1; gnt_period = 1;
        wr(2'd1, 32'h0000_0077);
        wr(2'd2, 32'hFFFF_FFF0);
        memimg.delete();
        wr(2'd0, 32'd1);
        wait_idle();
        check_image(32'h0000_0077, 32'hFFFF_FFF0);
        st_period = 2; gnt_period = 3;
        memimg.delete();
        wr(2'd0, 32'd1);
        check("R7", 32'(irq), 32'd1, "irq still high while new transfer runs");
        wait_idle();
        check_image(32'h0000_0077, 32'hFFFF_FFF0);
        wr(2'd3, 32'd0);
        check("R7", 32'(irq), 32'd0, "irq cleared after second transfer");

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule